// File: doc/BRIEF.md
# UART Receive FIFO with Per-Character Error Tracking

This block is the receive-side character queue of a UART. The receiver deserializer hands it one character per push, together with three error tags: framing, parity and break. Each tag stays attached to its own character inside the queue. The read side pops the oldest character. It sees that character, and the tags that belong to it, on combinational outputs driven from registered pointers. Those outputs are valid in the same cycle that the queue reports not-empty.

The block also keeps a running tally of the stored characters that carry any tag. A summary flag stays high while that tally is nonzero. The flag therefore falls only when the last flagged character has been read out, however many clean characters sit around it. An overrun indication from outside the block is ORed into the summary. A push into a full queue is dropped, and the block answers it with a one-cycle overrun pulse of its own.

Top module: `rx_err_fifo`

## Requirements
- R1: Characters leave the queue in the order they were pushed, and up to DEPTH (default 64) of them can be held at once.
- R2: `level` gives the number of stored characters. `empty` is high exactly when `level` is 0, and `full` is high exactly when `level` equals DEPTH. After reset, `level` is 0, `empty` is 1, and `full`, `any_err` and `ovr_pulse` are 0.
- R3: `top_fe`, `top_pe` and `top_brk` show the framing, parity and break tags pushed with the character currently at the head. After a pop, they show the tags of the new head character.
- R4: While the queue is empty, `top_fe`, `top_pe` and `top_brk` are all 0.
- R5: `any_err` is high while at least one stored character has a nonzero tag. It drops only after the last such character has been popped.
- R6: A high `ovr_in` drives `any_err` high in the same cycle, whatever the queue holds.
- R7: A push while `full` is high is dropped, even if a pop happens in the same cycle. The stored characters and `level` keep the values they would have without that push, and `ovr_pulse` is high for exactly the one cycle that follows the dropping clock edge.
- R8: A pop while `empty` is high is ignored: `level`, the tag tally and later read data are unaffected.
- R9: A push and a pop accepted at the same edge leave `level` unchanged. When both characters are tagged, `any_err` stays high.
- R10: `rd_char` equals the head character in every cycle where `empty` is low, with no extra cycle of read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push request from the receiver |
| wr_char | input | 8 | Character to push |
| wr_fe | input | 1 | Framing error tag of the pushed character |
| wr_pe | input | 1 | Parity error tag of the pushed character |
| wr_brk | input | 1 | Break tag of the pushed character |
| rd_en | input | 1 | Pop request |
| ovr_in | input | 1 | External overrun indication, merged into the summary |
| rd_char | output | 8 | Character at the head of the queue |
| top_fe | output | 1 | Framing tag of the head character |
| top_pe | output | 1 | Parity tag of the head character |
| top_brk | output | 1 | Break tag of the head character |
| any_err | output | 1 | Summary: a tagged character is stored, or `ovr_in` is high |
| level | output | 7 | Number of stored characters |
| empty | output | 1 | Queue holds no characters |
| full | output | 1 | Queue holds DEPTH characters |
| ovr_pulse | output | 1 | One-cycle pulse after a dropped push |

## Verification
The embedded properties assume that `wr_en`, `rd_en` and the tag inputs are known and stable around each rising edge. They also assume that a pop request may arrive at any time, including while the queue is empty. They make no assumption about pushes into a full queue, because the design must handle those itself. The directed stimulus changes every input only on falling edges and keeps them at defined levels throughout reset. Its deliberate underflow and overflow attempts therefore exercise the guarded paths without ever presenting unknown inputs.

// File: rtl/rx_err_fifo_pkg.sv
package rx_err_fifo_pkg;

  localparam int TAG_W = 3;

  typedef struct packed {
    logic brk;
    logic pe;
    logic fe;
  } rx_tag_t;

endpackage

// File: rtl/rxf_ptr_ctrl.sv
module rxf_ptr_ctrl #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          ovr_pulse
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  assign empty   = (level == '0);
  assign full    = (level == CAP);
  assign push_ok = wr_req && !full;
  assign pop_ok  = rd_req && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level     <= '0;
      ovr_pulse <= 1'b0;
    end else begin
      ovr_pulse <= wr_req && full;
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R2
  level_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    level <= CAP);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full && !rd_req) |=> (ovr_pulse && level == CAP));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && empty && !wr_req) |=> (level == '0 && $stable(rd_ptr)));

  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok) |=> $stable(level));

endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 11,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rxf_err_tally.sv
module rxf_err_tally #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  input  logic [CW-1:0] level,
  output logic          tagged_any
);

  logic [CW-1:0] tally;

  always_ff @(posedge clk) begin
    if (rst) tally <= '0;
    else begin
      case ({inc, dec})
        2'b10:   tally <= tally + 1'b1;
        2'b01:   tally <= tally - 1'b1;
        default: tally <= tally;
      endcase
    end
  end

  assign tagged_any = (tally != '0);

  // R5
  tally_bound_chk: assert property (@(posedge clk) disable iff (rst)
    tally <= level);

  // R5
  tally_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !(dec && !inc && tally == '0));

  // R9
  tally_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && dec) |=> $stable(tally));

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rx_err_fifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CHAR_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int EW = CHAR_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_char,
  input  logic              wr_fe,
  input  logic              wr_pe,
  input  logic              wr_brk,
  input  logic              rd_en,
  input  logic              ovr_in,
  output logic [CHAR_W-1:0] rd_char,
  output logic              top_fe,
  output logic              top_pe,
  output logic              top_brk,
  output logic              any_err,
  output logic [CW-1:0]     level,
  output logic              empty,
  output logic              full,
  output logic              ovr_pulse
);

  logic          push_ok, pop_ok, tagged_any;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [EW-1:0] wr_entry, rd_entry;
  rx_tag_t       in_tag, head_tag;

  assign in_tag   = '{brk: wr_brk, pe: wr_pe, fe: wr_fe};
  assign wr_entry = {in_tag, wr_char};

  rxf_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .wr_req(wr_en), .rd_req(rd_en),
    .push_ok(push_ok), .pop_ok(pop_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .level(level), .empty(empty), .full(full), .ovr_pulse(ovr_pulse)
  );

  rxf_store #(.DEPTH(DEPTH), .WIDTH(EW)) u_mem (
    .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(wr_entry),
    .raddr(rd_ptr), .rdata(rd_entry)
  );

  assign head_tag = empty ? '0 : rx_tag_t'(rd_entry[EW-1:CHAR_W]);

  rxf_err_tally #(.DEPTH(DEPTH)) u_tally (
    .clk(clk), .rst(rst),
    .inc(push_ok && (in_tag != '0)),
    .dec(pop_ok && (head_tag != '0)),
    .level(level), .tagged_any(tagged_any)
  );

  assign rd_char = rd_entry[CHAR_W-1:0];
  assign top_fe  = head_tag.fe;
  assign top_pe  = head_tag.pe;
  assign top_brk = head_tag.brk;
  assign any_err = tagged_any || ovr_in;

  // R4
  empty_tags_zero_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> !(top_fe || top_pe || top_brk));

  // R5
  tag_implies_summary_chk: assert property (@(posedge clk) disable iff (rst)
    (top_fe || top_pe || top_brk) |-> any_err);

  // R6
  ovr_summary_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_in |-> any_err);

endmodule

// File: tb/tb_rx_err_fifo.sv
module tb_rx_err_fifo;

  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_fe = 1'b0, wr_pe = 1'b0, wr_brk = 1'b0;
  logic       rd_en = 1'b0, ovr_in = 1'b0;
  logic [7:0] wr_char = '0;
  logic [7:0] rd_char;
  logic       top_fe, top_pe, top_brk, any_err, empty, full, ovr_pulse;
  logic [6:0] level;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [10:0] model[$];
  bit          exp_ovr = 1'b0;

  always #10 clk = ~clk;

  rx_err_fifo dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_char(wr_char), .wr_fe(wr_fe),
    .wr_pe(wr_pe), .wr_brk(wr_brk), .rd_en(rd_en), .ovr_in(ovr_in),
    .rd_char(rd_char), .top_fe(top_fe), .top_pe(top_pe), .top_brk(top_brk),
    .any_err(any_err), .level(level), .empty(empty), .full(full),
    .ovr_pulse(ovr_pulse)
  );

  function automatic bit model_tagged();
    foreach (model[i]) if (model[i][10:8] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check_all(input string req);
    logic [7:0] ec;
    logic [2:0] et;
    logic       ee;
    ec = (model.size() > 0) ? model[0][7:0] : rd_char;
    et = (model.size() > 0) ? model[0][10:8] : 3'b000;
    ee = model_tagged() || ovr_in;
    n_vec++;
    if (level !== 7'(model.size()) || empty !== (model.size() == 0) ||
        full !== (model.size() == DEPTH) || rd_char !== ec ||
        {top_brk, top_pe, top_fe} !== et || any_err !== ee ||
        ovr_pulse !== exp_ovr) begin
      n_bad++;
      $display("FAIL %s: got lvl=%0d emp=%b ful=%b ch=%h tag=%b err=%b ovr=%b exp lvl=%0d emp=%b ful=%b ch=%h tag=%b err=%b ovr=%b",
               req, level, empty, full, rd_char, {top_brk, top_pe, top_fe}, any_err,
               ovr_pulse, model.size(), model.size() == 0, model.size() == DEPTH,
               ec, et, ee, exp_ovr);
    end
  endtask

  task automatic step(input bit wr, input logic [7:0] ch, input logic [2:0] tg,
                      input bit rd, input string req);
    bit pop_ok, push_ok;
    wr_en = wr; wr_char = ch; {wr_brk, wr_pe, wr_fe} = tg; rd_en = rd;
    @(posedge clk);
    pop_ok  = rd && model.size() > 0;
    push_ok = wr && model.size() < DEPTH;
    exp_ovr = wr && model.size() == DEPTH;
    if (pop_ok)  void'(model.pop_front());
    if (push_ok) model.push_back({tg, ch});
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check_all(req);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model.delete(); exp_ovr = 1'b0;
    @(negedge clk);
    check_all("R2 reset");
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) step(1, 8'h30 + 8'(i), 3'b000, 0, "R1 push");
    for (int i = 0; i < 5; i++) step(0, 8'h00, 3'b000, 1, "R10 pop order");
  endtask

  task automatic t_tags();
    step(1, 8'hA1, 3'b000, 0, "R5 clean push");
    step(1, 8'hA2, 3'b001, 0, "R5 fe push");
    step(1, 8'hA3, 3'b000, 0, "R5 clean push");
    step(1, 8'hA4, 3'b110, 0, "R5 pe brk push");
    step(1, 8'hA5, 3'b000, 0, "R5 clean push");
    step(0, 8'h00, 3'b000, 1, "R3 pop to fe head");
    step(0, 8'h00, 3'b000, 1, "R3 pop past fe");
    step(0, 8'h00, 3'b000, 1, "R3 pop to pe brk head");
    step(0, 8'h00, 3'b000, 1, "R5 last tagged gone");
    step(0, 8'h00, 3'b000, 1, "R4 empty tags zero");
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++)
      step(1, 8'(i), (i == 40) ? 3'b100 : 3'b000, 0, "R1 fill");
    step(1, 8'hEE, 3'b011, 0, "R7 dropped push pulse");
    @(negedge clk); exp_ovr = 1'b0;
    check_all("R7 pulse one cycle");
    step(1, 8'hEF, 3'b001, 1, "R7 drop with pop");
    for (int i = 1; i < DEPTH; i++) step(0, 8'h00, 3'b000, 1, "R5 drain in order");
    step(0, 8'h00, 3'b000, 1, "R2 drained");
  endtask

  task automatic t_underflow();
    step(0, 8'h00, 3'b000, 1, "R8 pop empty");
    step(1, 8'h5A, 3'b000, 0, "R8 push after");
    step(0, 8'h00, 3'b000, 1, "R8 data intact");
  endtask

  task automatic t_simul();
    step(1, 8'h11, 3'b010, 0, "R9 prime");
    step(1, 8'h22, 3'b001, 1, "R9 push pop tagged");
    step(1, 8'h33, 3'b000, 1, "R9 push clean pop tagged");
    step(1, 8'h44, 3'b000, 1, "R9 empty push pop");
    step(0, 8'h00, 3'b000, 1, "R9 final pop");
  endtask

  task automatic t_ovr_in();
    ovr_in = 1'b1; #1;
    check_all("R6 ovr_in on empty");
    @(negedge clk); ovr_in = 1'b0; #1;
    check_all("R6 ovr_in released");
  endtask

  initial begin
    t_reset();
    t_order();
    t_tags();
    t_fill();
    t_underflow();
    t_simul();
    t_ovr_in();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule